// File: doc/BRIEF.md
# Tick-Driven Leaky Integrate-and-Fire Neuron

This block models one digital spiking neuron that advances in discrete ticks. Each tick brings a wide vector of input axon events. For every axon the block keeps one connection bit and a two-bit class code, and it holds four signed weights, one for each class. An event on a connected axon adds the weight of that axon's class to a saturating 20-bit signed potential. After all axons are summed, a signed leak is added. The result is compared against a non-negative firing level. The potential is then reset on a spike, or pulled to zero on a deep negative excursion, and finally clamped at zero if the floor option is set. A spike is not presented at once. It is queued and appears on the output a programmed number of ticks later.

A tick enters on a valid/ready handshake. A tick is accepted on a clock edge where `tick_valid` and `tick_ready` are both high. `tick_ready` then stays low while the axons are summed, `LANES` axons per clock. When `tick_ready` is low the producer must hold the tick, and no tick is lost. When the tick is finished the block raises `done` for one clock, updates `potential`, and drives `spike_out` in that same clock. Configuration uses plain pins. All settings are captured on a `cfg_we` pulse, and the same pulse loads the potential with a start value.

Top module: `lif_neuron`

## Requirements
- R1: A tick adds, for every axon i whose event bit and connection bit `cfg_conn[i]` are both 1, the signed 9-bit weight `cfg_weights[9k+8:9k]` where k = `cfg_class[2i+1:2i]`. Axons whose connection bit is 0 add nothing.
- R2: The signed leak `cfg_leak` is added once per tick, after the synaptic sum and before the firing comparison.
- R3: A spike is generated when the potential after the leak is greater than or equal to the unsigned level `cfg_fire_lvl`. At most one spike is generated per tick.
- R4: On a spike, if `cfg_linear` is 0 the potential becomes `cfg_after_fire`. If `cfg_linear` is 1, `cfg_fire_lvl` is subtracted from the potential instead.
- R5: When `cfg_floor` is 1, any negative result at the end of a tick is replaced by 0.
- R6: When no spike is generated and the potential after the leak is less than or equal to minus `cfg_sink_lvl`, the potential is forced to 0.
- R7: A spike generated in tick t is presented on `spike_out` together with the `done` pulse of tick t+d, where d = `cfg_delay` (1 to 15). The value 0 is treated as 1. `spike_out` is high only when `done` is high.
- R8: Every addition saturates at +524287 and at -524288 instead of wrapping.
- R9: `tick_ready` falls in the clock after a tick is accepted. `done` is a one-clock pulse that appears N_AXON/LANES+2 clocks after the accepting edge, and `tick_ready` is high again in that same clock.
- R10: A `cfg_we` pulse in a clock where `tick_ready` is 1 and `tick_valid` is 0 captures all settings and sets the potential to `cfg_init_pot`. A pulse in any other clock is ignored.
- R11: After reset the potential is 0, `tick_ready` is 1, and `done` and `spike_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_valid | input | 1 | A tick is offered |
| tick_ready | output | 1 | Block can accept a tick |
| tick_axons | input | 256 | Axon event bits of the tick |
| cfg_we | input | 1 | Capture all settings and load the start potential |
| cfg_conn | input | 256 | Connection bit per axon |
| cfg_class | input | 512 | Two-bit class code per axon |
| cfg_weights | input | 36 | Four signed 9-bit weights, class k at bits 9k+8:9k |
| cfg_leak | input | 9 | Signed leak added per tick |
| cfg_fire_lvl | input | 20 | Unsigned firing level |
| cfg_sink_lvl | input | 20 | Magnitude of the negative reset level |
| cfg_after_fire | input | 20 | Signed potential loaded on a spike in load mode |
| cfg_linear | input | 1 | 1 selects subtract-on-spike |
| cfg_floor | input | 1 | 1 clamps negative results to 0 |
| cfg_delay | input | 4 | Spike delay in ticks |
| cfg_init_pot | input | 20 | Signed start potential |
| done | output | 1 | One-clock pulse when a tick is finished |
| spike_out | output | 1 | Delayed spike, valid with done |
| potential | output | 20 | Current signed potential |

## Verification
Some properties are checked on every clock. These are the handshake timing (ready drops after acceptance, and done is a single pulse), that a spike never shows without done, and that the floor keeps the potential non-negative. The arithmetic can only be shown by the bench's scenarios. This covers the per-class weights gated by connection bits, the leak, the two reset modes, the negative reset, saturation, the exact tick delay including the zero-as-one case, and a configuration write that is ignored during integration. The bench's tick model predicts each of these before the tick is sent.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int V_W     = 20;
  localparam int W_W     = 9;
  localparam int N_CLS   = 4;
  localparam int CLS_W   = 2;
  localparam int DLY_W   = 4;
  localparam int MAX_DLY = (1 << DLY_W) - 1;
  localparam int EXT_W   = V_W + 4;

  typedef logic signed [V_W-1:0] pot_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FIN} lif_state_e;

  function automatic pot_t sat_pot(input logic signed [EXT_W-1:0] x);
    logic signed [EXT_W-1:0] hi;
    logic signed [EXT_W-1:0] lo;
    hi = {{(EXT_W-V_W+1){1'b0}}, {(V_W-1){1'b1}}};
    lo = {{(EXT_W-V_W+1){1'b1}}, {(V_W-1){1'b0}}};
    if (x > hi)      return hi[V_W-1:0];
    else if (x < lo) return lo[V_W-1:0];
    else             return x[V_W-1:0];
  endfunction
endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs
  import lif_pkg::*;
#(
  parameter int N_AXON = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic [N_AXON-1:0]      conn_d,
  input  logic [CLS_W*N_AXON-1:0] class_d,
  input  logic [N_CLS*W_W-1:0]   weights_d,
  input  logic [W_W-1:0]         leak_d,
  input  logic [V_W-1:0]         fire_d,
  input  logic [V_W-1:0]         sink_d,
  input  logic [V_W-1:0]         after_d,
  input  logic                   linear_d,
  input  logic                   floor_d,
  input  logic [DLY_W-1:0]       delay_d,
  output logic [N_AXON-1:0]      conn_q,
  output logic [CLS_W*N_AXON-1:0] class_q,
  output logic [N_CLS*W_W-1:0]   weights_q,
  output logic [W_W-1:0]         leak_q,
  output logic [V_W-1:0]         fire_q,
  output logic [V_W-1:0]         sink_q,
  output logic [V_W-1:0]         after_q,
  output logic                   linear_q,
  output logic                   floor_q,
  output logic [DLY_W-1:0]       delay_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q    <= '0;
      class_q   <= '0;
      weights_q <= '0;
      leak_q    <= '0;
      fire_q    <= '1;
      sink_q    <= '1;
      after_q   <= '0;
      linear_q  <= 1'b0;
      floor_q   <= 1'b0;
      delay_q   <= DLY_W'(1);
    end else if (take) begin
      conn_q    <= conn_d;
      class_q   <= class_d;
      weights_q <= weights_d;
      leak_q    <= leak_d;
      fire_q    <= fire_d;
      sink_q    <= sink_d;
      after_q   <= after_d;
      linear_q  <= linear_d;
      floor_q   <= floor_d;
      delay_q   <= delay_d;
    end
  end
endmodule

// File: rtl/lif_syn_accum.sv
module lif_syn_accum
  import lif_pkg::*;
#(
  parameter int N_AXON = 256,
  parameter int LANES  = 32,
  localparam int CHUNKS = N_AXON / LANES,
  localparam int CNT_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  localparam int SUM_W  = W_W + $clog2(LANES) + 1
) (
  input  logic [N_AXON-1:0]         axons,
  input  logic [N_AXON-1:0]         conn,
  input  logic [CLS_W*N_AXON-1:0]   classes,
  input  logic [N_CLS*W_W-1:0]      weights,
  input  logic [CNT_W-1:0]          chunk,
  output logic signed [SUM_W-1:0]   sum
);
  logic signed [SUM_W-1:0] term [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      int idx;
      logic [CLS_W-1:0] cls;
      logic signed [W_W-1:0] w;
      idx = int'(chunk) * LANES + l;
      cls = classes[CLS_W*idx +: CLS_W];
      w   = weights[int'(cls)*W_W +: W_W];
      term[l] = (axons[idx] && conn[idx]) ? SUM_W'(w) : '0;
    end
  end

  always_comb begin
    sum = '0;
    for (int l = 0; l < LANES; l++) sum = sum + term[l];
  end
endmodule

// File: rtl/lif_soma.sv
module lif_soma
  import lif_pkg::*;
(
  input  pot_t              acc,
  input  logic [W_W-1:0]    leak,
  input  logic [V_W-1:0]    fire_lvl,
  input  logic [V_W-1:0]    sink_lvl,
  input  pot_t              after_fire,
  input  logic              linear,
  input  logic              floor_en,
  output pot_t              v_next,
  output logic              fire
);
  pot_t vl;
  logic signed [V_W:0]   vl_x;
  logic signed [V_W:0]   lvl_x;
  logic signed [V_W+1:0] vl_w;
  logic signed [V_W+1:0] sink_x;
  logic signed [V_W:0]   diff;

  always_comb begin
    vl     = sat_pot(EXT_W'(acc) + EXT_W'($signed(leak)));
    vl_x   = {vl[V_W-1], vl};
    lvl_x  = {1'b0, fire_lvl};
    vl_w   = {{2{vl[V_W-1]}}, vl};
    sink_x = -$signed({2'b00, sink_lvl});
    diff   = vl_x - lvl_x;
    fire   = (vl_x >= lvl_x);
    v_next = vl;
    if (fire) v_next = linear ? diff[V_W-1:0] : after_fire;
    else if (vl_w <= sink_x) v_next = '0;
    if (floor_en && v_next[V_W-1]) v_next = '0;
  end
endmodule

// File: rtl/lif_delay.sv
module lif_delay
  import lif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             fire,
  input  logic [DLY_W-1:0] delay,
  output logic             spike
);
  logic [MAX_DLY:1] pend;
  logic [MAX_DLY:1] pend_nxt;
  logic [DLY_W-1:0] eff;

  always_comb begin
    eff = (delay == '0) ? DLY_W'(1) : delay;
    pend_nxt = '0;
    for (int k = 1; k < MAX_DLY; k++) pend_nxt[k] = pend[k+1];
    if (fire) pend_nxt[int'(eff)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      spike <= 1'b0;
    end else begin
      spike <= adv ? pend[1] : 1'b0;
      if (adv) pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int N_AXON = 256,
  parameter int LANES  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_valid,
  output logic                    tick_ready,
  input  logic [N_AXON-1:0]       tick_axons,
  input  logic                    cfg_we,
  input  logic [N_AXON-1:0]       cfg_conn,
  input  logic [2*N_AXON-1:0]     cfg_class,
  input  logic [35:0]             cfg_weights,
  input  logic [8:0]              cfg_leak,
  input  logic [19:0]             cfg_fire_lvl,
  input  logic [19:0]             cfg_sink_lvl,
  input  logic [19:0]             cfg_after_fire,
  input  logic                    cfg_linear,
  input  logic                    cfg_floor,
  input  logic [3:0]              cfg_delay,
  input  logic [19:0]             cfg_init_pot,
  output logic                    done,
  output logic                    spike_out,
  output logic [19:0]             potential
);
  localparam int CHUNKS = N_AXON / LANES;
  localparam int CNT_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
  localparam int SUM_W  = W_W + $clog2(LANES) + 1;

  lif_state_e state;
  logic [CNT_W-1:0]  cnt;
  logic [N_AXON-1:0] ax_q;
  pot_t acc, v_q, v_next;
  logic done_q, fire, cfg_take;
  logic signed [SUM_W-1:0] chunk_sum;

  logic [N_AXON-1:0]       conn_q;
  logic [CLS_W*N_AXON-1:0] class_q;
  logic [N_CLS*W_W-1:0]    weights_q;
  logic [W_W-1:0]          leak_q;
  logic [V_W-1:0]          fire_q, sink_q, after_q;
  logic                    linear_q, floor_q;
  logic [DLY_W-1:0]        delay_q;

  assign tick_ready = (state == ST_IDLE);
  assign cfg_take   = cfg_we && tick_ready && !tick_valid;
  assign done       = done_q;
  assign potential  = v_q;

  lif_cfg_regs #(.N_AXON(N_AXON)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(cfg_take),
    .conn_d(cfg_conn), .class_d(cfg_class), .weights_d(cfg_weights),
    .leak_d(cfg_leak), .fire_d(cfg_fire_lvl), .sink_d(cfg_sink_lvl),
    .after_d(cfg_after_fire), .linear_d(cfg_linear), .floor_d(cfg_floor),
    .delay_d(cfg_delay),
    .conn_q(conn_q), .class_q(class_q), .weights_q(weights_q),
    .leak_q(leak_q), .fire_q(fire_q), .sink_q(sink_q), .after_q(after_q),
    .linear_q(linear_q), .floor_q(floor_q), .delay_q(delay_q)
  );

  lif_syn_accum #(.N_AXON(N_AXON), .LANES(LANES)) u_acc (
    .axons(ax_q), .conn(conn_q), .classes(class_q), .weights(weights_q),
    .chunk(cnt), .sum(chunk_sum)
  );

  lif_soma u_soma (
    .acc(acc), .leak(leak_q), .fire_lvl(fire_q), .sink_lvl(sink_q),
    .after_fire(after_q), .linear(linear_q), .floor_en(floor_q),
    .v_next(v_next), .fire(fire)
  );

  lif_delay u_dly (
    .clk(clk), .rst_n(rst_n), .adv(state == ST_FIN), .fire(fire),
    .delay(delay_q), .spike(spike_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ax_q   <= '0;
      acc    <= '0;
      v_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tick_valid) begin
            ax_q  <= tick_axons;
            acc   <= v_q;
            cnt   <= '0;
            state <= ST_ACC;
          end else if (cfg_take) begin
            v_q <= cfg_init_pot;
          end
        end
        ST_ACC: begin
          acc <= sat_pot(EXT_W'(acc) + EXT_W'(chunk_sum));
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(CHUNKS - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          v_q    <= v_next;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && tick_ready) |=> !tick_ready);
  assert_floor_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && floor_q) |-> !potential[19]);
  assert_spike_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spike_out |-> done);
endmodule

// File: tb/lif_neuron_test.sv
module lif_neuron_test;
  logic clk = 0;
  logic rst_n = 0;
  logic tick_valid = 0;
  logic tick_ready;
  logic [255:0] tick_axons = '0;
  logic cfg_we = 0;
  logic [255:0] cfg_conn = '0;
  logic [511:0] cfg_class = '0;
  logic [35:0] cfg_weights = '0;
  logic [8:0] cfg_leak = '0;
  logic [19:0] cfg_fire_lvl = '0, cfg_sink_lvl = '0, cfg_after_fire = '0, cfg_init_pot = '0;
  logic cfg_linear = 0, cfg_floor = 0;
  logic [3:0] cfg_delay = 4'd1;
  logic done, spike_out;
  logic [19:0] potential;

  lif_neuron uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int qv[$]; bit qs[$]; string qt[$];

  int m_w[4]; bit m_conn[256]; int m_cls[256];
  int m_leak, m_fire, m_sink, m_after, m_dly, m_v;
  bit m_lin, m_floor;
  bit m_pend[16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int clampv(input int x);
    if (x > 524287) return 524287;
    if (x < -524288) return -524288;
    return x;
  endfunction

  task automatic write_cfg(input int w0, input int w1, input int w2, input int w3,
                           input int leak, input int fire, input int sink, input int after,
                           input bit lin, input bit flr, input int dly, input int init);
    m_w[0] = w0; m_w[1] = w1; m_w[2] = w2; m_w[3] = w3;
    for (int i = 0; i < 256; i++) begin
      m_conn[i] = 1; m_cls[i] = i % 4;
      cfg_conn[i] = 1'b1; cfg_class[2*i +: 2] = 2'(i % 4);
    end
    for (int i = 0; i < 8; i++) begin m_conn[i] = 0; cfg_conn[i] = 1'b0; end
    cfg_weights = {9'(w3), 9'(w2), 9'(w1), 9'(w0)};
    m_leak = leak; cfg_leak = 9'(leak);
    m_fire = fire; cfg_fire_lvl = 20'(fire);
    m_sink = sink; cfg_sink_lvl = 20'(sink);
    m_after = after; cfg_after_fire = 20'(after);
    m_lin = lin; cfg_linear = lin;
    m_floor = flr; cfg_floor = flr;
    m_dly = dly; cfg_delay = 4'(dly);
    m_v = init; cfg_init_pot = 20'(init);
    @(negedge clk); cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic predict(input logic [255:0] ax, input string tag);
    int s; int v; bit f; bit sp; int d;
    s = 0;
    for (int i = 0; i < 256; i++) if (ax[i] && m_conn[i]) s += m_w[m_cls[i]];
    v = clampv(m_v + s);
    v = clampv(v + m_leak);
    f = (v >= m_fire);
    if (f) v = m_lin ? v - m_fire : m_after;
    else if (v <= -m_sink) v = 0;
    if (m_floor && v < 0) v = 0;
    m_v = v;
    sp = m_pend[1];
    for (int k = 1; k < 15; k++) m_pend[k] = m_pend[k+1];
    m_pend[15] = 0;
    d = (m_dly == 0) ? 1 : m_dly;
    if (f) m_pend[d] = 1;
    qv.push_back(v); qs.push_back(sp); qt.push_back(tag);
  endtask

  task automatic do_tick(input logic [255:0] ax, input string tag, input bit busy_cfg);
    int cyc;
    predict(ax, tag);
    @(negedge clk); tick_valid = 1; tick_axons = ax;
    @(negedge clk); tick_valid = 0;
    cyc = 1;
    if (busy_cfg) begin
      cfg_init_pot = 20'd12345; cfg_weights = '0; cfg_we = 1;
      @(negedge clk); cfg_we = 0; cyc++;
    end
    while (!done) begin @(negedge clk); cyc++; end
    chk(cyc == 10, "R9 done latency", cyc, 10);
    chk(tick_ready == 1'b1, "R9 ready with done", int'(tick_ready), 1);
  endtask

  always @(negedge clk) begin
    if (rst_n && done && qv.size() > 0) begin
      int ev; bit es; string t;
      ev = qv.pop_front(); es = qs.pop_front(); t = qt.pop_front();
      chk(int'($signed(potential)) == ev, {t, " potential"}, int'($signed(potential)), ev);
      chk(spike_out == es, {t, " spike R7"}, int'(spike_out), int'(es));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R9 actual=hang expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] p01, p23, all1, t0only;
    for (int i = 0; i < 16; i++) m_pend[i] = 0;
    for (int i = 0; i < 256; i++) begin
      p01[i] = (i % 4) < 2; p23[i] = (i % 4) >= 2;
      all1[i] = 1'b1; t0only[i] = (i % 4) == 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(potential == 20'd0, "R11 potential", int'(potential), 0);
    chk(tick_ready == 1'b1, "R11 ready", int'(tick_ready), 1);
    chk(done == 1'b0, "R11 done", int'(done), 0);
    chk(spike_out == 1'b0, "R11 spike", int'(spike_out), 0);

    // R1 per-class weights, connection gating
    write_cfg(1, 16, -1, -16, 0, 1048575, 1048575, 0, 0, 0, 1, 0);
    do_tick(p01, "R1", 0);
    do_tick(p23, "R1", 0);
    do_tick(all1, "R1", 0);
    for (int r = 0; r < 3; r++)
      do_tick({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, "R1", 0);

    // R2 leak
    write_cfg(1, 16, -1, -16, -5, 1048575, 1048575, 0, 0, 0, 1, 100);
    for (int r = 0; r < 3; r++) do_tick('0, "R2", 0);

    // R3 R4 R7 load-mode reset and delay 3
    write_cfg(10, 0, 0, 0, 0, 100, 1048575, -3, 0, 0, 3, 0);
    do_tick(t0only, "R3 R4", 0);
    for (int r = 0; r < 5; r++) do_tick('0, "R7", 0);

    // R4 linear mode, delay 1
    write_cfg(10, 0, 0, 0, 0, 100, 1048575, 0, 1, 0, 1, 0);
    do_tick(t0only, "R4", 0);
    for (int r = 0; r < 4; r++) do_tick('0, "R4 R3", 0);

    // R5 floor
    write_cfg(-10, 0, 0, 0, 0, 1048575, 1048575, 0, 0, 1, 1, 0);
    for (int r = 0; r < 3; r++) do_tick(t0only, "R5", 0);

    // R6 negative reset
    write_cfg(-2, 0, 0, 0, 0, 1048575, 300, 0, 0, 0, 1, 0);
    for (int r = 0; r < 4; r++) do_tick(t0only, "R6", 0);

    // R8 saturation
    write_cfg(255, 255, 255, 255, 0, 1048575, 1048575, 0, 0, 0, 1, 0);
    for (int r = 0; r < 10; r++) do_tick(all1, "R8", 0);

    // R7 delay 0 behaves as 1
    write_cfg(10, 0, 0, 0, 0, 100, 1048575, 0, 0, 0, 0, 0);
    do_tick(t0only, "R7", 0);
    do_tick('0, "R7", 0);
    do_tick('0, "R7", 0);

    // R10 configuration pulse during integration ignored
    write_cfg(3, 0, 0, 0, 0, 1048575, 1048575, 0, 0, 0, 1, 7);
    chk(int'($signed(potential)) == 7, "R10 init load", int'($signed(potential)), 7);
    do_tick(t0only, "R10", 1);
    do_tick(t0only, "R10", 0);

    repeat (3) @(negedge clk);
    chk(qv.size() == 0, "R9 all ticks completed", qv.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule